// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the software-facing register file of an SMBus host controller. A byte-wide register port exposes status, control, command, target address, two data bytes and a 32-entry block buffer reached through one auto-indexing data window. Writing the control register with its start bit set decodes a 3-bit protocol code together with the direction bit of the address register. The block then presents a single abstract transfer request to a bus engine and waits for that engine's response.

The bit-level bus signalling lives in the engine, not here. The engine gets the latched request fields and a private port into the block buffer. For block writes it reads the buffer through that port; for block reads it fills the buffer through it. When the engine responds, any returned bytes are stored into the data registers and a done flag is raised. Register offsets (byte address on `reg_addr`): 0 status, 2 control, 3 command, 4 target address, 5 data low, 6 data high, 7 block window. Status bits are: bit 0 busy, bit 1 done, bit 2 error.

Top module: `smb_host_regs`

## Requirements
- R1: After synchronous reset the status, control, command, address and both data registers read 0, and `req_valid` is low.
- R2: A control write with bit 6 set while idle, with a supported protocol code in bits 4:2 (0 quick, 1 single byte, 2 byte with command, 3 word, 5 block), raises `req_valid` on the next cycle. The request carries the protocol code, `req_read` from address bit 0, `req_target` from address bits 7:1, the command byte, and `req_wdata` = {data high, data low}. The start also sets status busy and clears done.
- R3: A start with protocol code 4, 6 or 7 issues no request and sets status bit 2 (error).
- R4: On `rsp_valid` after acceptance, busy clears and done sets. For reads with codes 1, 2 or 5, data low takes `rsp_data[7:0]` (the byte count for block). For code 3, data low takes `rsp_data[7:0]` and data high takes `rsp_data[15:8]`. Quick transfers and writes leave both data registers unchanged.
- R5: While busy, host writes to control, command, address, data and the block window are ignored, including a second start.
- R6: Each access to offset 7 reads or writes the buffer entry at the current index and then advances the index, which wraps to 0 after entry 31.
- R7: Any write to status clears done and error and returns the block index to 0.
- R8: A read of control returns its bits 4:0 with bits 7:5 zero, and returns the block index to 0.
- R9: While busy, the engine port writes buffer entries that the host can later read, and it reads back the bytes the host wrote, one cycle after the address is presented.
- R10: Read data appears on `reg_rdata` one cycle after `reg_rd` and holds until the next read; unmapped offsets read 0.
- R11: `req_valid` stays high, with its fields unchanged, until a cycle with `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the strobe |
| req_valid | output | 1 | Transfer request to the bus engine |
| req_ready | input | 1 | Engine accepts the request |
| req_proto | output | 3 | Protocol code of the request |
| req_read | output | 1 | Request direction, 1 = read |
| req_target | output | 7 | 7-bit target address |
| req_cmd | output | 8 | Command byte |
| req_wdata | output | 16 | Outgoing {high, low} data; low holds the block count |
| rsp_valid | input | 1 | Engine signals completion |
| rsp_data | input | 16 | Returned {high, low} data |
| eng_buf_addr | input | IDX_W | Engine buffer index |
| eng_buf_we | input | 1 | Engine buffer write enable, honoured while busy |
| eng_buf_wdata | input | 8 | Engine buffer write byte |
| eng_buf_rdata | output | 8 | Engine buffer read byte, one cycle latency |

## Verification
The properties assume that the host never asserts `reg_wr` and `reg_rd` in the same cycle. They also assume the engine raises `rsp_valid` only after it has taken a request with `req_ready`, and drives the buffer port only while a transfer is open. The stimulus drives each register access as one isolated strobe, changes inputs on the falling edge, and plays the engine through tasks that accept, optionally touch the buffer, and then respond once per request.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_STAT = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CTL  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CMD  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_ADR  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_DLO  = 3'd5;
  localparam logic [REG_AW-1:0] OFS_DHI  = 3'd6;
  localparam logic [REG_AW-1:0] OFS_BLK  = 3'd7;

  localparam int START_BIT = 6;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/smb_proto_dec.sv
module smb_proto_dec
  import smb_host_pkg::*;
(
  input  logic [2:0] code,
  output logic       supported,
  output logic       is_word,
  output logic       loads_lo
);
  always_comb begin
    supported = (code == PR_QUICK) || (code == PR_BYTE) || (code == PR_BDATA) ||
                (code == PR_WORD)  || (code == PR_BLOCK);
    is_word   = (code == PR_WORD);
    loads_lo  = (code == PR_BYTE) || (code == PR_BDATA) ||
                (code == PR_WORD) || (code == PR_BLOCK);
  end
endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             ha_en,
  input  logic [IDX_W-1:0] ha_addr,
  output logic [7:0]       ha_q,
  input  logic [IDX_W-1:0] eb_addr,
  output logic [7:0]       eb_q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (ha_en) ha_q <= mem[ha_addr];
  end

  always_ff @(posedge clk) begin
    eb_q <= mem[eb_addr];
  end
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_proto,
  output logic              req_read,
  output logic [6:0]        req_target,
  output logic [7:0]        req_cmd,
  output logic [15:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  input  logic [IDX_W-1:0]  eng_buf_addr,
  input  logic              eng_buf_we,
  input  logic [7:0]        eng_buf_wdata,
  output logic [7:0]        eng_buf_rdata
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUF_DEPTH - 1);

  xfer_state_e      state_q;
  logic [4:0]       ctl_q;
  logic [7:0]       cmd_q, adr_q, dlo_q, dhi_q;
  logic             done_q, err_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rd_q;
  logic             rd_blk_q;
  logic             word_q, loads_q;
  logic [7:0]       buf_hq;

  logic busy, waiting, host_ok, start_req, rsp_take, blk_acc;
  logic dec_sup, dec_word, dec_lo;

  assign busy      = (state_q != XS_IDLE);
  assign waiting   = (state_q == XS_WAIT);
  assign host_ok   = reg_wr && !busy;
  assign start_req = host_ok && (reg_addr == OFS_CTL) && reg_wdata[START_BIT];
  assign rsp_take  = waiting && rsp_valid;
  assign blk_acc   = (host_ok && reg_addr == OFS_BLK) || (reg_rd && reg_addr == OFS_BLK);
  assign req_valid = (state_q == XS_REQ);
  assign reg_rdata = rd_blk_q ? buf_hq : rd_q;

  smb_proto_dec u_dec (
    .code      (reg_wdata[4:2]),
    .supported (dec_sup),
    .is_word   (dec_word),
    .loads_lo  (dec_lo)
  );

  smb_blk_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .we      (busy ? eng_buf_we : (host_ok && reg_addr == OFS_BLK)),
    .waddr   (busy ? eng_buf_addr : idx_q),
    .wdata   (busy ? eng_buf_wdata : reg_wdata),
    .ha_en   (reg_rd && reg_addr == OFS_BLK),
    .ha_addr (idx_q),
    .ha_q    (buf_hq),
    .eb_addr (eng_buf_addr),
    .eb_q    (eng_buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= XS_IDLE;
      ctl_q      <= '0;
      cmd_q      <= '0;
      adr_q      <= '0;
      dlo_q      <= '0;
      dhi_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      idx_q      <= '0;
      rd_q       <= '0;
      rd_blk_q   <= 1'b0;
      word_q     <= 1'b0;
      loads_q    <= 1'b0;
      req_proto  <= '0;
      req_read   <= 1'b0;
      req_target <= '0;
      req_cmd    <= '0;
      req_wdata  <= '0;
    end else begin
      // transfer sequencing
      unique case (state_q)
        XS_IDLE: if (start_req && dec_sup) begin
          state_q    <= XS_REQ;
          req_proto  <= reg_wdata[4:2];
          req_read   <= adr_q[0];
          req_target <= adr_q[7:1];
          req_cmd    <= cmd_q;
          req_wdata  <= {dhi_q, dlo_q};
          word_q     <= dec_word;
          loads_q    <= dec_lo;
        end
        XS_REQ:  if (req_ready) state_q <= XS_WAIT;
        XS_WAIT: if (rsp_valid) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase

      // host register writes, frozen while a transfer is open
      if (host_ok) begin
        unique case (reg_addr)
          OFS_CTL: ctl_q <= reg_wdata[4:0];
          OFS_CMD: cmd_q <= reg_wdata;
          OFS_ADR: adr_q <= reg_wdata;
          OFS_DLO: dlo_q <= reg_wdata;
          OFS_DHI: dhi_q <= reg_wdata;
          default: ;
        endcase
      end

      // status flags: clear first, completion and start events win
      if (reg_wr && reg_addr == OFS_STAT) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (start_req && !dec_sup) err_q <= 1'b1;
      if (start_req && dec_sup) done_q <= 1'b0;
      if (rsp_take) begin
        done_q <= 1'b1;
        if (req_read && loads_q) dlo_q <= rsp_data[7:0];
        if (req_read && word_q)  dhi_q <= rsp_data[15:8];
      end

      // block window index
      if ((reg_wr && reg_addr == OFS_STAT) || (reg_rd && reg_addr == OFS_CTL))
        idx_q <= '0;
      else if (blk_acc)
        idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;

      // registered read path
      if (reg_rd) begin
        rd_blk_q <= (reg_addr == OFS_BLK);
        unique case (reg_addr)
          OFS_STAT: rd_q <= {5'b0, err_q, done_q, busy};
          OFS_CTL:  rd_q <= {3'b0, ctl_q};
          OFS_CMD:  rd_q <= cmd_q;
          OFS_ADR:  rd_q <= adr_q;
          OFS_DLO:  rd_q <= dlo_q;
          OFS_DHI:  rd_q <= dhi_q;
          default:  rd_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk
  import smb_host_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic              wdata_start,
  input logic [2:0]        wdata_code,
  input logic [2:0]        rdata_hi,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_proto,
  input logic [7:0]        req_cmd,
  input logic [6:0]        req_target,
  input logic              rsp_valid,
  input logic              busy,
  input logic              waiting,
  input logic              done,
  input logic              err
);
  logic ctl_start, code_bad;
  assign ctl_start = reg_wr && (reg_addr == OFS_CTL) && wdata_start;
  assign code_bad  = (wdata_code == 3'd4) || (wdata_code == 3'd6) || (wdata_code == 3'd7);

  AST_GOOD_START: assert property (@(posedge clk) disable iff (rst)
    ctl_start && !busy && !code_bad |=> req_valid && busy); // R2

  AST_BAD_PROTO: assert property (@(posedge clk) disable iff (rst)
    ctl_start && !busy && code_bad |=> !req_valid && err); // R3

  AST_DONE_ON_RSP: assert property (@(posedge clk) disable iff (rst)
    waiting && rsp_valid |=> !busy && done); // R4

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ctl_start && busy |=> $stable(req_proto) && $stable(req_cmd) && $stable(req_target)); // R5

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == OFS_STAT && !(waiting && rsp_valid) |=> !done && !err); // R7

  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == OFS_CTL |=> rdata_hi == 3'b000); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_proto) && $stable(req_cmd) && $stable(req_target)); // R11
endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .wdata_start (reg_wdata[6]),
  .wdata_code  (reg_wdata[4:2]),
  .rdata_hi    (reg_rdata[7:5]),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_proto   (req_proto),
  .req_cmd     (req_cmd),
  .req_target  (req_target),
  .rsp_valid   (rsp_valid),
  .busy        (busy),
  .waiting     (waiting),
  .done        (done_q),
  .err         (err_q)
);

// File: tb/smb_host_regs_bench.sv
module smb_host_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        req_valid, req_read;
  logic        req_ready = 1'b0;
  logic [2:0]  req_proto;
  logic [6:0]  req_target;
  logic [7:0]  req_cmd;
  logic [15:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic [IDX_W-1:0] eng_buf_addr = '0;
  logic        eng_buf_we = 1'b0;
  logic [7:0]  eng_buf_wdata = '0;
  logic [7:0]  eng_buf_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_host_regs u_smb_host_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_proto(req_proto), .req_read(req_read),
    .req_target(req_target), .req_cmd(req_cmd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .eng_buf_addr(eng_buf_addr),
    .eng_buf_we(eng_buf_we), .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
  );

  // {write, offset, data, expected read}
  localparam logic [19:0] VEC [18] = '{
    {1'b1, 3'd3, 8'hA5, 8'h00}, {1'b0, 3'd3, 8'h00, 8'hA5},
    {1'b1, 3'd4, 8'h6B, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h6B},
    {1'b1, 3'd5, 8'h11, 8'h00}, {1'b0, 3'd5, 8'h00, 8'h11},
    {1'b1, 3'd6, 8'h22, 8'h00}, {1'b0, 3'd6, 8'h00, 8'h22},
    {1'b1, 3'd2, 8'h9F, 8'h00}, {1'b0, 3'd2, 8'h00, 8'h1F},
    {1'b0, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'h00}, {1'b1, 3'd7, 8'h30, 8'h00},
    {1'b1, 3'd7, 8'h31, 8'h00}, {1'b0, 3'd2, 8'h00, 8'h1F},
    {1'b0, 3'd7, 8'h00, 8'h30}, {1'b0, 3'd7, 8'h00, 8'h31}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic accept();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic respond(input logic [15:0] d);
    rsp_valid = 1'b1; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 req_valid", {15'b0, req_valid}, 16'h0);
    rd(3'd0, v); check("R1 status", {8'h0, v}, 16'h0000);
    rd(3'd5, v); check("R1 data low", {8'h0, v}, 16'h0000);
    rd(3'd2, v); check("R1 control", {8'h0, v}, 16'h0000);

    // table walk: R10 plain registers, R8 control, R6 block window
    for (int i = 0; i < 18; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][18:16], v);
        if (VEC[i][18:16] == 3'd2)      check("R8 table", {8'h0, v}, {8'h0, VEC[i][7:0]});
        else if (VEC[i][18:16] == 3'd7) check("R6 table", {8'h0, v}, {8'h0, VEC[i][7:0]});
        else                            check("R10 table", {8'h0, v}, {8'h0, VEC[i][7:0]});
      end
    end

    // R6 wrap after last entry, R7 index reset by status write
    wr(3'd0, 8'h00);
    for (int i = 0; i < 33; i++) wr(3'd7, 8'(i));
    wr(3'd0, 8'hFF);
    rd(3'd7, v); check("R6 wrap entry0", {8'h0, v}, 16'h0020);
    rd(3'd7, v); check("R6 wrap entry1", {8'h0, v}, 16'h0001);

    // R3 unsupported codes, R7 clearing
    for (int c = 4; c < 8; c++) begin
      if (c != 5) begin
        wr(3'd2, 8'h40 | 8'(c << 2));
        check("R3 no request", {15'b0, req_valid}, 16'h0);
        rd(3'd0, v); check("R3 error flag", {8'h0, v}, 16'h0004);
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R7 status cleared", {8'h0, v}, 16'h0000);
      end
    end

    // R2 word write request, R5 ignore while busy, R11 hold
    wr(3'd5, 8'h34); wr(3'd6, 8'h12); wr(3'd3, 8'h0C); wr(3'd4, 8'hA0);
    wr(3'd2, 8'h4C);
    check("R2 req_valid", {15'b0, req_valid}, 16'h1);
    check("R2 proto", {13'b0, req_proto}, 16'h0003);
    check("R2 dir", {15'b0, req_read}, 16'h0);
    check("R2 target", {9'b0, req_target}, 16'h0050);
    check("R2 cmd", {8'b0, req_cmd}, 16'h000C);
    check("R2 wdata", req_wdata, 16'h1234);
    rd(3'd0, v); check("R2 busy", {8'h0, v}, 16'h0001);
    wr(3'd5, 8'h99); wr(3'd3, 8'h55); wr(3'd2, 8'h40);
    check("R11 still requesting", {15'b0, req_valid}, 16'h1);
    check("R5 proto kept", {13'b0, req_proto}, 16'h0003);
    accept();
    check("R11 dropped after ready", {15'b0, req_valid}, 16'h0);
    respond(16'hFFFF);
    @(negedge clk);
    check("R5 no second request", {15'b0, req_valid}, 16'h0);
    rd(3'd0, v); check("R4 done", {8'h0, v}, 16'h0002);
    rd(3'd5, v); check("R5 data low kept", {8'h0, v}, 16'h0034);
    rd(3'd3, v); check("R5 cmd kept", {8'h0, v}, 16'h000C);

    // R4 word read
    wr(3'd4, 8'hA1); wr(3'd2, 8'h4C);
    check("R2 read dir", {15'b0, req_read}, 16'h1);
    accept(); respond(16'hBEEF);
    rd(3'd5, v); check("R4 word low", {8'h0, v}, 16'h00EF);
    rd(3'd6, v); check("R4 word high", {8'h0, v}, 16'h00BE);

    // R4 quick read leaves data; byte-data read loads low only
    wr(3'd2, 8'h40); accept(); respond(16'h1111);
    rd(3'd5, v); check("R4 quick keeps low", {8'h0, v}, 16'h00EF);
    wr(3'd2, 8'h48); accept(); respond(16'h0055);
    rd(3'd5, v); check("R4 byte low", {8'h0, v}, 16'h0055);
    rd(3'd6, v); check("R4 byte keeps high", {8'h0, v}, 16'h00BE);

    // R9 block write: engine reads host bytes
    wr(3'd0, 8'h00);
    wr(3'd7, 8'hC0); wr(3'd7, 8'hC1); wr(3'd7, 8'hC2);
    wr(3'd5, 8'h03); wr(3'd4, 8'hA0); wr(3'd2, 8'h54);
    check("R2 block count", req_wdata[7:0], 8'h03);
    accept();
    eng_buf_addr = 5'd1;
    @(negedge clk);
    check("R9 engine read", {8'h0, eng_buf_rdata}, 16'h00C1);
    respond(16'h0000);

    // R9 block read: engine fills, host reads back, R4 count
    wr(3'd4, 8'hA1); wr(3'd2, 8'h54); accept();
    eng_buf_we = 1'b1; eng_buf_addr = 5'd0; eng_buf_wdata = 8'hD0;
    @(negedge clk);
    eng_buf_addr = 5'd1; eng_buf_wdata = 8'hD1;
    @(negedge clk);
    eng_buf_we = 1'b0;
    respond(16'h0002);
    rd(3'd5, v); check("R4 block count", {8'h0, v}, 16'h0002);
    rd(3'd2, v);
    rd(3'd7, v); check("R9 filled entry0", {8'h0, v}, 16'h00D0);
    rd(3'd7, v); check("R9 filled entry1", {8'h0, v}, 16'h00D1);
    @(negedge clk);
    check("R10 read data held", {8'h0, reg_rdata}, 16'h00D1);

    finish_run();
  end
endmodule